// File: doc/BRIEF.md
# Byte-Serial Seconds Clock with 1904 Epoch

This block is the time-of-day unit of a power controller. It holds a 32-bit count of seconds measured from midnight, 1 January 1904. A parameterised prescaler turns the core clock into a one-cycle pulse each second, and that pulse advances a free-running elapsed-seconds counter. The time the block reports is the sum of this counter and a stored offset. Writing the time changes only the offset, so the seconds pulse never stops or restarts.

Commands arrive as a header and a stream of bytes. The header is an opcode plus an argument length. It is followed by exactly that many argument bytes, one per cycle while the unit accepts them. A read command returns a four-byte big-endian snapshot on a response stream. A write command takes four big-endian argument bytes. A command that is malformed or unknown has its arguments consumed and is then dropped, with no response and no change of state. The initial offset comes from a Unix-style seconds parameter, moved to the 1904 epoch at reset.

Top module: `rtc_cmd_unit`

## Requirements
- R1: After reset `hdr_ready_o` is high, `rsp_valid_o` is low, and the first read returns INIT_UNIX_SEC + 2082844800, modulo 2^32, plus the seconds elapsed since reset.
- R2: `tick_o` is a one-cycle pulse that repeats every TICKS_PER_SEC cycles.
- R3: Each tick raises the reported time by exactly one. The 32-bit value wraps from 0xFFFFFFFF to 0.
- R4: A read uses opcode 0x51 with length 0. In the cycle after the header is accepted, the time is snapshotted. The snapshot is returned as four bytes on consecutive cycles, starting the following cycle, most significant byte first. `rsp_last_o` is high only on the fourth byte.
- R5: A read whose length is not 0 consumes its arguments, gives no response, and leaves the time unchanged.
- R6: A write uses opcode 0x52 with length 4 and takes its argument bytes most significant first. Later reads count on from the written value, and the tick is not paused. A write gives no response.
- R7: A write whose length is not 4 consumes its arguments, gives no response, and leaves the time unchanged.
- R8: When a write takes effect in a cycle that also carries a tick, the next read returns exactly the written value.
- R9: Any other opcode has its arguments consumed. It gives no response and has no effect on the time.
- R10: `hdr_ready_o` is high only while the unit is idle, and `arg_ready_o` is high only while arguments are expected. While a response is being sent, `hdr_ready_o` is low. It returns high in the cycle after the last response byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Command header present |
| hdr_op_i | input | 8 | Command opcode |
| hdr_len_i | input | 8 | Number of argument bytes that follow |
| hdr_ready_o | output | 1 | Unit idle, header accepted this cycle if valid |
| arg_valid_i | input | 1 | Argument byte present |
| arg_data_i | input | 8 | Argument byte |
| arg_ready_o | output | 1 | Unit is collecting argument bytes |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_data_o | output | 8 | Response byte |
| rsp_last_o | output | 1 | Final response byte |
| tick_o | output | 1 | One-cycle seconds pulse |

## Verification
The bench steers a write so that it takes effect in the same cycle as a seconds pulse. A design that loads the offset against the pre-tick count would then read back one second ahead. It sends reads and writes with wrong lengths, including one longer than four bytes and an unknown opcode. A design that looks only at the opcode would answer or alter the time, and one that miscounts arguments would lose framing for the next command. It also writes just below the 32-bit limit and crosses it, which exposes a design that saturates or mishandles the carry. Every read is compared byte by byte against a model that follows the written value and counts the seconds pulses, so a design with swapped byte order or a misplaced last flag fails.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W    = 8;
  localparam int TIME_W    = 32;
  localparam int TIME_BYTES = TIME_W / BYTE_W;

  // seconds between 1904-01-01 and 1970-01-01
  localparam logic [TIME_W-1:0] EPOCH_GAP_1904 = 32'd2082844800;

  localparam logic [BYTE_W-1:0] OP_TIME_RD = 8'h51;
  localparam logic [BYTE_W-1:0] OP_TIME_WR = 8'h52;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARGS,
    ST_EXEC,
    ST_RESP
  } ctl_state_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICKS <= 1) begin : g_every_cycle
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= 1'b1;
      end
      assign tick_o = tick_q;
    end else begin : g_divider
      localparam int CW = $clog2(TICKS);
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
#(
  parameter logic [TIME_W-1:0] INIT_UNIX_SEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              set_i,
  input  logic [TIME_W-1:0] set_val_i,
  output logic [TIME_W-1:0] time_o
);
  localparam logic [TIME_W-1:0] OFFSET_RST = INIT_UNIX_SEC + EPOCH_GAP_1904;

  logic [TIME_W-1:0] elapsed_q, elapsed_nxt;
  logic [TIME_W-1:0] offset_q;

  assign elapsed_nxt = elapsed_q + TIME_W'(tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      offset_q  <= OFFSET_RST;
    end else begin
      elapsed_q <= elapsed_nxt;
      // referenced to the post-tick count so a coincident tick is absorbed
      if (set_i) offset_q <= set_val_i - elapsed_nxt;
    end
  end

  assign time_o = offset_q + elapsed_q;
endmodule

// File: rtl/rtc_byte_ser.sv
module rtc_byte_ser
  import rtc_pkg::*;
#(
  parameter int NBYTES = TIME_BYTES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NBYTES*BYTE_W-1:0] word_i,
  output logic                     valid_o,
  output logic [BYTE_W-1:0]        data_o,
  output logic                     last_o
);
  localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] TOP = CW'(NBYTES - 1);

  logic [NBYTES*BYTE_W-1:0] sr_q;
  logic [CW-1:0]            left_q;
  logic                     busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= word_i;
      left_q <= TOP;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sr_q   <= sr_q << BYTE_W;
      left_q <= left_q - 1'b1;
      if (left_q == '0) busy_q <= 1'b0;
    end
  end

  assign valid_o = busy_q;
  assign data_o  = sr_q[NBYTES*BYTE_W-1 -: BYTE_W];
  assign last_o  = busy_q && (left_q == '0);
endmodule

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl
  import rtc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic [BYTE_W-1:0] hdr_op_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  output logic              hdr_ready_o,
  input  logic              arg_valid_i,
  input  logic [BYTE_W-1:0] arg_data_i,
  output logic              arg_ready_o,
  input  logic [TIME_W-1:0] cur_time_i,
  input  logic              ser_last_i,
  output logic              set_o,
  output logic [TIME_W-1:0] set_val_o,
  output logic              load_o,
  output logic [TIME_W-1:0] word_o
);
  localparam logic [LEN_W-1:0] RD_LEN = '0;
  localparam logic [LEN_W-1:0] WR_LEN = LEN_W'(TIME_BYTES);

  ctl_state_e        state_q;
  logic [BYTE_W-1:0] op_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [TIME_W-1:0] arg_sr_q;
  logic              rd_ok, wr_ok, args_done;

  assign rd_ok     = (op_q == OP_TIME_RD) && (len_q == RD_LEN);
  assign wr_ok     = (op_q == OP_TIME_WR) && (len_q == WR_LEN);
  assign args_done = ({1'b0, cnt_q} + 1'b1) == {1'b0, len_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      arg_sr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (hdr_valid_i) begin
          op_q    <= hdr_op_i;
          len_q   <= hdr_len_i;
          cnt_q   <= '0;
          state_q <= (hdr_len_i == '0) ? ST_EXEC : ST_ARGS;
        end
        ST_ARGS: if (arg_valid_i) begin
          arg_sr_q <= {arg_sr_q[TIME_W-BYTE_W-1:0], arg_data_i};
          cnt_q    <= cnt_q + 1'b1;
          if (args_done) state_q <= ST_EXEC;
        end
        ST_EXEC: state_q <= rd_ok ? ST_RESP : ST_IDLE;
        ST_RESP: if (ser_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hdr_ready_o = (state_q == ST_IDLE);
  assign arg_ready_o = (state_q == ST_ARGS);
  assign set_o       = (state_q == ST_EXEC) && wr_ok;
  assign set_val_o   = arg_sr_q;
  assign load_o      = (state_q == ST_EXEC) && rd_ok;
  assign word_o      = cur_time_i;
endmodule

// File: rtl/rtc_cmd_unit.sv
module rtc_cmd_unit
  import rtc_pkg::*;
#(
  parameter int unsigned       TICKS_PER_SEC = 100_000_000,
  parameter logic [TIME_W-1:0] INIT_UNIX_SEC = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hdr_valid_i,
  input  logic [7:0] hdr_op_i,
  input  logic [7:0] hdr_len_i,
  output logic       hdr_ready_o,
  input  logic       arg_valid_i,
  input  logic [7:0] arg_data_i,
  output logic       arg_ready_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       rsp_last_o,
  output logic       tick_o
);
  logic              wr_en;
  logic [TIME_W-1:0] wr_val;
  logic [TIME_W-1:0] cur_time;
  logic              snap_load;
  logic [TIME_W-1:0] snap_word;

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_o)
  );

  rtc_timebase #(.INIT_UNIX_SEC(INIT_UNIX_SEC)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_o),
    .set_i    (wr_en),
    .set_val_i(wr_val),
    .time_o   (cur_time)
  );

  rtc_cmd_ctrl #(.LEN_W(8)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hdr_valid_i(hdr_valid_i),
    .hdr_op_i   (hdr_op_i),
    .hdr_len_i  (hdr_len_i),
    .hdr_ready_o(hdr_ready_o),
    .arg_valid_i(arg_valid_i),
    .arg_data_i (arg_data_i),
    .arg_ready_o(arg_ready_o),
    .cur_time_i (cur_time),
    .ser_last_i (rsp_last_o),
    .set_o      (wr_en),
    .set_val_o  (wr_val),
    .load_o     (snap_load),
    .word_o     (snap_word)
  );

  rtc_byte_ser #(.NBYTES(TIME_BYTES)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (snap_load),
    .word_i (snap_word),
    .valid_o(rsp_valid_o),
    .data_o (rsp_data_o),
    .last_o (rsp_last_o)
  );
endmodule

// File: rtl/rtc_cmd_unit_chk.sv
module rtc_cmd_unit_chk #(
  parameter int unsigned TICKS = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        set_i,
  input logic [31:0] set_val_i,
  input logic [31:0] time_i,
  input logic        hdr_ready_i,
  input logic        arg_ready_i,
  input logic        rsp_valid_i,
  input logic        rsp_last_i
);
  localparam bit MULTI = (TICKS > 1);

  p_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MULTI && tick_i) |=> !tick_i);

  p_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_i) |=> time_i == $past(time_i) + 32'd1);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !set_i) |=> $stable(time_i));

  p_set_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> time_i == $past(set_val_i));

  p_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !rsp_last_i) |=> rsp_valid_i);

  p_last_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_i |=> !rsp_valid_i);

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> !hdr_ready_i);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ready_i |-> !arg_ready_i);

  p_ready_back_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_i |=> hdr_ready_i);
endmodule

bind rtc_cmd_unit rtc_cmd_unit_chk #(.TICKS(TICKS_PER_SEC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_o),
  .set_i      (wr_en),
  .set_val_i  (wr_val),
  .time_i     (cur_time),
  .hdr_ready_i(hdr_ready_o),
  .arg_ready_i(arg_ready_o),
  .rsp_valid_i(rsp_valid_o),
  .rsp_last_i (rsp_last_o)
);

// File: tb/rtc_cmd_unit_test.sv
`timescale 1ns/1ps
module rtc_cmd_unit_test;
  localparam int unsigned T    = 16;
  localparam logic [31:0] INIT = 32'd1_000_000_000;
  localparam logic [31:0] GAP  = 32'd2082844800;
  localparam logic [7:0]  RD   = 8'h51;
  localparam logic [7:0]  WR   = 8'h52;
  localparam int NV = 10;
  // {opcode, length, argument word}
  localparam logic [47:0] VEC [NV] = '{
    {RD,   8'd0, 32'h0000_0000},
    {WR,   8'd4, 32'h1234_5678},
    {RD,   8'd0, 32'h0000_0000},
    {RD,   8'd2, 32'hAABB_0000},
    {WR,   8'd3, 32'h0000_0001},
    {WR,   8'd5, 32'hDEAD_BEEF},
    {8'h7E,8'd2, 32'h0102_0000},
    {RD,   8'd0, 32'h0000_0000},
    {WR,   8'd4, 32'hFFFF_FFFE},
    {RD,   8'd0, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, arg_valid = 1'b0;
  logic [7:0] hdr_op = '0, hdr_len = '0, arg_data = '0;
  logic hdr_ready, arg_ready, rsp_valid, rsp_last, tick;
  logic [7:0] rsp_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] m_time;
  logic        pend_set = 1'b0;
  logic [31:0] pend_val = '0;

  always #2.5 clk = ~clk;

  rtc_cmd_unit #(.TICKS_PER_SEC(T), .INIT_UNIX_SEC(INIT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hdr_valid_i(hdr_valid), .hdr_op_i(hdr_op), .hdr_len_i(hdr_len),
    .hdr_ready_o(hdr_ready),
    .arg_valid_i(arg_valid), .arg_data_i(arg_data), .arg_ready_o(arg_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last),
    .tick_o(tick)
  );

  // reference time: follows writes, otherwise counts seconds pulses
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        m_time <= INIT + GAP;
    else if (pend_set) m_time <= pend_val;
    else if (tick)     m_time <= m_time + 32'd1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] len,
                         input logic [31:0] val);
    logic [31:0] exp;
    bit good_rd, good_wr;
    good_rd = (op == RD) && (len == 8'd0);
    good_wr = (op == WR) && (len == 8'd4);
    while (!hdr_ready) @(negedge clk);
    hdr_valid = 1'b1; hdr_op = op; hdr_len = len;
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int i = 0; i < int'(len); i++) begin
      chk(arg_ready == 1'b1 && hdr_ready == 1'b0, "R10 arg phase", {30'd0, arg_ready, hdr_ready}, 32'd2);
      arg_valid = 1'b1;
      arg_data  = (i < 4) ? val[31 - 8*i -: 8] : 8'hEE;
      @(negedge clk);
    end
    arg_valid = 1'b0;
    // execute cycle
    exp = m_time;
    if (good_wr) begin pend_set = 1'b1; pend_val = val; end
    @(negedge clk);
    pend_set = 1'b0;
    if (good_rd) begin
      for (int b = 0; b < 4; b++) begin
        chk(rsp_valid == 1'b1, "R4 rsp valid", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_data == exp[31 - 8*b -: 8], "R1,R3,R4,R6,R7,R8,R9 time byte",
            {24'd0, rsp_data}, {24'd0, exp[31 - 8*b -: 8]});
        chk(rsp_last == (b == 3), "R4 last flag", {31'd0, rsp_last}, (b == 3) ? 32'd1 : 32'd0);
        chk(hdr_ready == 1'b0, "R10 busy during rsp", {31'd0, hdr_ready}, 32'd0);
        @(negedge clk);
      end
      chk(hdr_ready == 1'b1 && rsp_valid == 1'b0, "R10 idle after rsp",
          {30'd0, hdr_ready, rsp_valid}, 32'd2);
    end else begin
      for (int k = 0; k < 4; k++) begin
        chk(rsp_valid == 1'b0, "R5,R6,R7,R9 no response", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hdr_ready == 1'b1, "R1 ready after reset", {31'd0, hdr_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R1 no rsp after reset", {31'd0, rsp_valid}, 32'd0);

    // R2: pulse period
    while (!tick) @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick);
      chk(gap == int'(T), "R2 tick period", gap, T);
    end

    // R1: first read reflects initial offset
    run_cmd(RD, 8'd0, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_cmd(VEC[v][47:40], VEC[v][39:32], VEC[v][31:0]);
      repeat (v % 3) @(negedge clk);
    end

    // R3: wrap across the 32-bit limit
    run_cmd(WR, 8'd4, 32'hFFFF_FFFF);
    while (!tick) @(negedge clk);
    @(negedge clk);
    run_cmd(RD, 8'd0, 32'd0);

    // R8: write executes in the same cycle as a tick
    while (!tick) @(negedge clk);
    repeat (T - 5) @(negedge clk);
    while (!hdr_ready) @(negedge clk);
    hdr_valid = 1'b1; hdr_op = WR; hdr_len = 8'd4;
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      arg_valid = 1'b1;
      arg_data  = 8'hC0 + 8'(i);
      @(negedge clk);
    end
    arg_valid = 1'b0;
    chk(tick == 1'b1, "R8 tick aligned with write", {31'd0, tick}, 32'd1);
    pend_set = 1'b1; pend_val = 32'hC0C1_C2C3;
    @(negedge clk);
    pend_set = 1'b0;
    run_cmd(RD, 8'd0, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule